// File: doc/BRIEF.md
# Periodic Ping Synchronizer and Segment Windower

This block locks onto an acoustic ping that repeats at a fixed period and, for every ping it sees, reports the stretch of the sample stream worth keeping for later processing. It watches a multi-channel stream of signed samples. A ping is declared on the first sample whose magnitude, on any channel, reaches a programmable threshold. A free-running microsecond timer stamps each crossing. A free-running sample counter gives every accepted sample an index.

After reset the block runs a long acquisition scan, `ACQ_US` microseconds long, and keeps the earliest crossing it finds. Once it has a crossing it becomes locked. It then waits, and opens only short tracking windows, `TRACK_US` long, centred on the last ping time plus `PERIOD_US`. If a tracking window passes with no crossing, lock is lost and the long scan starts again. For each ping found, the block emits a one-cycle strobe with the following values:
- the first kept sample index, which is the crossing index minus a pre-trigger span;
- the last kept sample index, which is the crossing index plus a post-trigger span;
- the ping time stamp.

A debug input turns this off. Instead, the block emits back-to-back full-scan windows without truncation. Typical settings are 100 µs before the crossing and 50 µs after it. A downstream sample store uses the indices to cut the segment out of its own history.

Top module: `ping_sync_window`

## Requirements
- R1: A crossing is a valid sample where, on at least one channel, the absolute value of the two's-complement sample is greater than or equal to the unsigned threshold. A sample one below the threshold never produces a segment or lock.
- R2: After reset, and after a loss of lock, the block scans for `ACQ_US` microsecond ticks with `locked` low. It keeps the earliest crossing in that scan, even if a later ping also falls in the scan.
- R3: When a scan ends with a crossing, `locked` rises in the same cycle as a `segValid` strobe for that crossing.
- R4: While locked, the next crossing is sought only in a window of `TRACK_US` ticks that starts `TRACK_US/2` ticks before the last ping time plus `PERIOD_US`. If that start time has already passed, the expected time advances by whole periods.
- R5: A tracking window that ends with no crossing drops `locked` without a `segValid` strobe and restarts the scan.
- R6: For a truncated segment, `pingTime` is the microsecond count at the crossing. `segStart` is the crossing index minus `preUs*SAMPLES_PER_US`, clamped at 0. `segEnd` is the crossing index plus `postUs*SAMPLES_PER_US`. Sample indices count valid samples from 0 after reset.
- R7: While `debugEn` is high, `locked` is low. Each window spans `ACQ_US` ticks, and `segStart`/`segEnd` cover the whole window. `pingTime` is left unchanged.
- R8: `segValid` is a single-cycle pulse, and `segStart`, `segEnd` and `pingTime` change only together with it.
- R9: In reset, `locked`, `segValid`, `segStart`, `segEnd` and `pingTime` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | One sample per channel is present |
| samples | input | NUM_CH*SAMPLE_W | Signed samples, channel k in bits k*SAMPLE_W upward |
| usTick | input | 1 | One-cycle pulse per microsecond |
| threshold | input | SAMPLE_W | Unsigned magnitude threshold |
| preUs | input | CFG_W | Microseconds kept before the crossing |
| postUs | input | CFG_W | Microseconds kept after the crossing |
| debugEn | input | 1 | Full-window capture without truncation |
| segValid | output | 1 | Segment report strobe |
| segStart | output | IDX_W | First kept sample index |
| segEnd | output | IDX_W | Last kept sample index |
| pingTime | output | TIME_W | Microsecond stamp of the crossing |
| locked | output | 1 | High while waiting for or tracking a known ping |

## Verification
The assertions check the following on every cycle:
- the strobe is a single-cycle pulse;
- the report fields stay stable between strobes;
- segments are ordered;
- lock is gained only together with a report and never lost with one;
- lock stays low during debug capture.

Only the bench scenarios can show the rest:
- that the earliest of two in-scan pings is kept;
- that the index arithmetic and the clamp at zero are right;
- that the tracking window lands on the right ping after a catch-up over a missed period;
- that a sub-threshold ping is rejected and a negative one accepted;
- that lock recovers after pings vanish.

// File: rtl/ping_sync_pkg.sv
package ping_sync_pkg;

  typedef enum logic [1:0] {
    ST_ACQUIRE = 2'd0,
    ST_WAIT    = 2'd1,
    ST_TRACK   = 2'd2,
    ST_DEBUG   = 2'd3
  } syncState_t;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic clearFind;  // forget any captured crossing
    logic armFind;    // accept a new first crossing
    logic markWin;    // remember current sample index as window start
    logic emitSeg;    // publish a segment report
    logic fullSpan;   // report whole window instead of truncated segment
  } ctrlStrobe_t;

endpackage

// File: rtl/ping_window_datapath.sv
module ping_window_datapath
  import ping_sync_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int SAMPLE_W       = 16,
  parameter int IDX_W          = 32,
  parameter int TIME_W         = 32,
  parameter int CFG_W          = 16,
  parameter int SAMPLES_PER_US = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic                       usTick,
  input  logic [SAMPLE_W-1:0]        threshold,
  input  logic [CFG_W-1:0]           preUs,
  input  logic [CFG_W-1:0]           postUs,
  input  ctrlStrobe_t                ctrl,
  output logic                       found,
  output logic [TIME_W-1:0]          hitTime,
  output logic [TIME_W-1:0]          usTime,
  output logic                       segValid,
  output logic [IDX_W-1:0]           segStart,
  output logic [IDX_W-1:0]           segEnd,
  output logic [TIME_W-1:0]          pingTime
);

  localparam logic [IDX_W-1:0] SPU = IDX_W'(SAMPLES_PER_US);

  logic [NUM_CH-1:0] chHit;
  logic              anyHit;
  logic [IDX_W-1:0]  sampIdx;
  logic [IDX_W-1:0]  hitIdx;
  logic [IDX_W-1:0]  winStartIdx;
  logic [IDX_W-1:0]  preSpan;
  logic [IDX_W-1:0]  postSpan;

  // Magnitude compare, one per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gMag
    logic [SAMPLE_W-1:0] raw;
    logic [SAMPLE_W:0]   ext;
    logic [SAMPLE_W:0]   mag;
    assign raw = samples[ch*SAMPLE_W +: SAMPLE_W];
    assign ext = {raw[SAMPLE_W-1], raw};
    assign mag = raw[SAMPLE_W-1] ? (~ext + 1'b1) : ext;
    assign chHit[ch] = mag >= {1'b0, threshold};
  end

  assign anyHit   = sampleValid && (|chHit);
  assign preSpan  = IDX_W'(preUs) * SPU;
  assign postSpan = IDX_W'(postUs) * SPU;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampIdx     <= '0;
      usTime      <= '0;
      found       <= 1'b0;
      hitIdx      <= '0;
      hitTime     <= '0;
      winStartIdx <= '0;
      segValid    <= 1'b0;
      segStart    <= '0;
      segEnd      <= '0;
      pingTime    <= '0;
    end else begin
      if (sampleValid) sampIdx <= sampIdx + IDX_W'(1);
      if (usTick)      usTime  <= usTime + TIME_W'(1);

      if (ctrl.clearFind) begin
        found <= 1'b0;
      end else if (ctrl.armFind && anyHit && !found) begin
        found   <= 1'b1;
        hitIdx  <= sampIdx;
        hitTime <= usTime;
      end

      if (ctrl.markWin) winStartIdx <= sampIdx;

      segValid <= ctrl.emitSeg;
      if (ctrl.emitSeg) begin
        if (ctrl.fullSpan) begin
          segStart <= winStartIdx;
          segEnd   <= sampIdx - IDX_W'(1);
        end else begin
          segStart <= (hitIdx >= preSpan) ? hitIdx - preSpan : '0;
          segEnd   <= hitIdx + postSpan;
          pingTime <= hitTime;
        end
      end
    end
  end

endmodule

// File: rtl/ping_sync_ctrl.sv
module ping_sync_ctrl
  import ping_sync_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int ACQ_US    = 2_100_000,
  parameter int PERIOD_US = 2_000_000,
  parameter int TRACK_US  = 250_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              debugEn,
  input  logic              found,
  input  logic [TIME_W-1:0] hitTime,
  input  logic [TIME_W-1:0] usTime,
  output ctrlStrobe_t       ctrl,
  output logic              locked
);

  localparam int WIN_W = $clog2(ACQ_US + 1);
  localparam int LEAD_US = TRACK_US / 2;
  localparam logic [TIME_W-1:0] OPEN_OFS = TIME_W'(PERIOD_US - LEAD_US);
  localparam logic [TIME_W-1:0] PERIOD_T = TIME_W'(PERIOD_US);
  localparam logic [WIN_W-1:0] ACQ_LAST = WIN_W'(ACQ_US - 1);
  localparam logic [WIN_W-1:0] TRK_LAST = WIN_W'(TRACK_US - 1);

  syncState_t        state, nextState;
  logic [WIN_W-1:0]  winCnt;
  logic [TIME_W-1:0] lastPing;
  logic [TIME_W-1:0] openDiff;
  logic              winEnd;
  logic              cntClr;
  logic              loadLast;
  logic              skipPeriod;

  assign openDiff = usTime - (lastPing + OPEN_OFS);
  assign winEnd   = usTick && (winCnt == ((state == ST_TRACK) ? TRK_LAST : ACQ_LAST));
  assign locked   = (state == ST_WAIT) || (state == ST_TRACK);

  always_comb begin
    nextState  = state;
    ctrl       = '0;
    cntClr     = 1'b0;
    loadLast   = 1'b0;
    skipPeriod = 1'b0;
    if (debugEn && state != ST_DEBUG) begin
      nextState    = ST_DEBUG;
      ctrl.markWin = 1'b1;
      cntClr       = 1'b1;
    end else begin
      unique case (state)
        ST_ACQUIRE: begin
          ctrl.armFind = 1'b1;
          if (winEnd) begin
            cntClr         = 1'b1;
            ctrl.clearFind = 1'b1;
            if (found) begin
              ctrl.emitSeg = 1'b1;
              loadLast     = 1'b1;
              nextState    = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (openDiff == '0) begin
            nextState      = ST_TRACK;
            cntClr         = 1'b1;
            ctrl.clearFind = 1'b1;
          end else if (!openDiff[TIME_W-1]) begin
            skipPeriod = 1'b1;
          end
        end
        ST_TRACK: begin
          ctrl.armFind = 1'b1;
          if (winEnd) begin
            cntClr         = 1'b1;
            ctrl.clearFind = 1'b1;
            if (found) begin
              ctrl.emitSeg = 1'b1;
              loadLast     = 1'b1;
              nextState    = ST_WAIT;
            end else begin
              nextState = ST_ACQUIRE;
            end
          end
        end
        ST_DEBUG: begin
          if (!debugEn) begin
            nextState      = ST_ACQUIRE;
            cntClr         = 1'b1;
            ctrl.clearFind = 1'b1;
          end else if (winEnd) begin
            ctrl.emitSeg  = 1'b1;
            ctrl.fullSpan = 1'b1;
            ctrl.markWin  = 1'b1;
            cntClr        = 1'b1;
          end
        end
        default: nextState = ST_ACQUIRE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_ACQUIRE;
      winCnt   <= '0;
      lastPing <= '0;
    end else begin
      state <= nextState;
      if (cntClr)      winCnt <= '0;
      else if (usTick) winCnt <= winCnt + WIN_W'(1);
      if (loadLast)        lastPing <= hitTime;
      else if (skipPeriod) lastPing <= lastPing + PERIOD_T;
    end
  end

endmodule

// File: rtl/ping_sync_window.sv
module ping_sync_window
  import ping_sync_pkg::*;
#(
  parameter int NUM_CH         = 4,
  parameter int SAMPLE_W       = 16,
  parameter int IDX_W          = 32,
  parameter int TIME_W         = 32,
  parameter int CFG_W          = 16,
  parameter int SAMPLES_PER_US = 5,
  parameter int ACQ_US         = 2_100_000,
  parameter int PERIOD_US      = 2_000_000,
  parameter int TRACK_US       = 250_000
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic                       usTick,
  input  logic [SAMPLE_W-1:0]        threshold,
  input  logic [CFG_W-1:0]           preUs,
  input  logic [CFG_W-1:0]           postUs,
  input  logic                       debugEn,
  output logic                       segValid,
  output logic [IDX_W-1:0]           segStart,
  output logic [IDX_W-1:0]           segEnd,
  output logic [TIME_W-1:0]          pingTime,
  output logic                       locked
);

  ctrlStrobe_t       ctrl;
  logic              found;
  logic [TIME_W-1:0] hitTime;
  logic [TIME_W-1:0] usTime;

  ping_sync_ctrl #(
    .TIME_W(TIME_W), .ACQ_US(ACQ_US), .PERIOD_US(PERIOD_US), .TRACK_US(TRACK_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .usTick(usTick), .debugEn(debugEn),
    .found(found), .hitTime(hitTime), .usTime(usTime),
    .ctrl(ctrl), .locked(locked)
  );

  ping_window_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W), .TIME_W(TIME_W),
    .CFG_W(CFG_W), .SAMPLES_PER_US(SAMPLES_PER_US)
  ) uData (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .samples(samples),
    .usTick(usTick), .threshold(threshold), .preUs(preUs), .postUs(postUs),
    .ctrl(ctrl), .found(found), .hitTime(hitTime), .usTime(usTime),
    .segValid(segValid), .segStart(segStart), .segEnd(segEnd), .pingTime(pingTime)
  );

endmodule

// File: rtl/ping_sync_window_chk.sv
module ping_sync_window_chk #(
  parameter int IDX_W  = 32,
  parameter int TIME_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              debugEn,
  input logic              segValid,
  input logic [IDX_W-1:0]  segStart,
  input logic [IDX_W-1:0]  segEnd,
  input logic [TIME_W-1:0] pingTime,
  input logic              locked
);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    segValid |=> !segValid) else $error("strobe wider than one cycle"); // R8

  AST_START_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !segValid |-> $stable(segStart)) else $error("segStart moved"); // R8

  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !segValid |-> $stable(pingTime)) else $error("pingTime moved"); // R8

  AST_SEG_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> segStart <= segEnd) else $error("segment reversed"); // R6

  AST_LOCK_WITH_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> segValid) else $error("lock without report"); // R3

  AST_LOSS_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> !segValid) else $error("report on loss"); // R5

  AST_DEBUG_UNLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $past(debugEn) |-> !locked) else $error("locked in debug"); // R7

endmodule

bind ping_sync_window ping_sync_window_chk #(.IDX_W(IDX_W), .TIME_W(TIME_W)) uChk (
  .clk(clk), .rstN(rstN), .debugEn(debugEn), .segValid(segValid),
  .segStart(segStart), .segEnd(segEnd), .pingTime(pingTime), .locked(locked)
);

// File: tb/tb_ping_sync_window.sv
module tb_ping_sync_window;

  localparam int NUM_CH = 4;
  localparam int SW     = 16;
  localparam int SPU    = 4;
  localparam int PER    = 200;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [NUM_CH*SW-1:0] samples = '0;
  logic usTick = 1'b0;
  logic [SW-1:0] threshold = 16'd300;
  logic [15:0] preUs = 16'd10;
  logic [15:0] postUs = 16'd5;
  logic debugEn = 1'b0;
  logic segValid;
  logic [31:0] segStart, segEnd, pingTime;
  logic locked;

  always #4 clk = ~clk;  // 125 MHz

  ping_sync_window #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SW), .IDX_W(32), .TIME_W(32), .CFG_W(16),
    .SAMPLES_PER_US(SPU), .ACQ_US(210), .PERIOD_US(PER), .TRACK_US(25)
  ) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .samples(samples),
    .usTick(usTick), .threshold(threshold), .preUs(preUs), .postUs(postUs),
    .debugEn(debugEn), .segValid(segValid), .segStart(segStart),
    .segEnd(segEnd), .pingTime(pingTime), .locked(locked)
  );

  // Stimulus: one sample per cycle, a tick every 4 cycles, a ping of 4
  // samples whenever (cycle/4) mod PER equals pingOff.
  int rstCnt = 3;
  int cyc = 0;
  bit pingOn = 1'b0;
  int pingOff = 0, pingCh = 0, pingAmp = 0;

  always @(negedge clk) begin
    if (rstCnt > 0) begin
      rstN = 1'b0; rstCnt--; cyc = 0;
      sampleValid = 1'b0; usTick = 1'b0; samples = '0;
    end else begin
      rstN = 1'b1;
      sampleValid = 1'b1;
      usTick = (cyc % 4) == 3;
      samples = '0;
      if (pingOn && ((cyc / 4) % PER) == pingOff)
        samples[pingCh*SW +: SW] = SW'(pingAmp);
      cyc++;
    end
  end

  int nChecks = 0, nFail = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstCnt = 3;
    repeat (5) @(posedge clk);
    #2;
  endtask

  // Wait for a segment strobe; got=0 on timeout
  task automatic waitSeg(input int maxCyc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxCyc; i++) begin
      @(posedge clk); #2;
      if (segValid) begin got = 1'b1; break; end
    end
  endtask

  // offset, pre, post, channel, amplitude, next tracked ping time
  localparam int VEC[4][6] = '{
    '{5,   10, 5,  0,  500, 405},   // R2 earliest of two in scan, R6 clamp, R4 catch-up
    '{60,  10, 5,  1, -500, 260},   // R1 negative sample
    '{100, 0,  0,  2,  700, 300},
    '{30,  3,  20, 3,  300, 230}    // R1 exactly at threshold
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    bit got;
    int t;
    int spanA;
    bit sawSeg;

    for (int v = 0; v < 4; v++) begin
      preUs = 16'(VEC[v][1]); postUs = 16'(VEC[v][2]);
      pingOff = VEC[v][0]; pingCh = VEC[v][3]; pingAmp = VEC[v][4];
      pingOn = 1'b1;
      doReset();
      if (v == 0) begin
        chk("R9 locked", locked, 0);
        chk("R9 segStart", segStart, 0);
        chk("R9 pingTime", pingTime, 0);
      end
      repeat (100) @(posedge clk); #2;
      chk("R2 unlocked during scan", locked, 0);
      waitSeg(2000, got);
      chk("R3 segment after scan", got, 1);
      chk("R3 locked with report", locked, 1);
      t = VEC[v][0];
      chk("R2 R6 pingTime", pingTime, t);
      chk("R6 segStart", segStart, (4*t >= VEC[v][1]*SPU) ? 4*t - VEC[v][1]*SPU : 0);
      chk("R6 segEnd", segEnd, 4*t + VEC[v][2]*SPU);
      waitSeg(2000, got);
      chk("R4 tracked ping time", pingTime, VEC[v][5]);
      chk("R4 still locked", locked, 1);
    end

    // Continue from last entry (offset 30, pre 3, post 20): ping at 430
    waitSeg(2000, got);
    chk("R4 tracked 430", pingTime, 430);
    chk("R6 tracked segStart", segStart, 1720 - 12);
    chk("R6 tracked segEnd", segEnd, 1720 + 80);

    // Loss of lock
    pingOn = 1'b0;
    sawSeg = 1'b0;
    for (int i = 0; i < 2000 && locked; i++) begin
      @(posedge clk); #2;
      if (segValid) sawSeg = 1'b1;
    end
    chk("R5 lock dropped", locked, 0);
    chk("R5 no report on loss", sawSeg, 0);
    pingOn = 1'b1;
    waitSeg(2000, got);
    chk("R5 reacquired", got, 1);
    chk("R5 reacquired ping time", pingTime, 830);
    chk("R5 relocked", locked, 1);

    // Sub-threshold ping is ignored
    pingOff = 50; pingCh = 2; pingAmp = 299;
    doReset();
    waitSeg(4000, got);
    chk("R1 below threshold no segment", got, 0);
    chk("R1 below threshold unlocked", locked, 0);

    // Debug full windows
    pingAmp = 600; debugEn = 1'b1;
    doReset();
    waitSeg(2000, got);
    chk("R7 debug window", got, 1);
    chk("R7 unlocked", locked, 0);
    chk("R7 pingTime untouched", pingTime, 0);
    waitSeg(2000, got);
    spanA = int'(segEnd) - int'(segStart) + 1;
    chk("R7 full span", spanA >= 836 && spanA <= 844, 1);
    chk("R7 contiguous", got, 1);
    debugEn = 1'b0;

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule